// File: doc/BRIEF.md
# Rearmable Time Alarm Comparator

The block watches a free-running 64-bit time value and raises an alarm once the time reaches a programmed compare value. Software programs the compare value as two 32-bit halves through a small register port. Arming follows a fixed sequence. Writing the lower half first disarms the comparator. Writing the upper half after that arms it again with the new 64-bit value. The alarm therefore never fires on a value that is only half updated.

When an armed comparator sees a time equal to or greater than its compare value, it does three things. It sets a sticky event flag. It emits a one-cycle start strobe, which can start a downstream periodic pulse generator (the strobe is active high, so the rising edge marks the start). It then disarms itself. Because the test is greater-or-equal, a compare value that is already in the past fires on the first cycle after arming. The time counter is an input to the block. Combining interrupts from several sources is left to other logic.

Top module: `time_alarm_cmp`

## Requirements
- R1: After reset, both compare halves read back as all ones, the block is armed, the event flag is 0 and the start strobe is low. Register select 0 is the lower half (compare bits 31:0), select 1 is the upper half (bits 63:32), and select 2 is control. Control reads bit 0 as the event flag and bit 1 as the armed state.
- R2: While armed, a time equal to or greater than the compare value produces a start strobe exactly one clock after that time is presented on the input.
- R3: The start strobe lasts one cycle, and the event flag is 1 whenever the strobe is 1.
- R4: The alarm fires at most once per arming. After it fires, the block is disarmed and later times give no strobe.
- R5: A write to the lower half stores the value, disarms the block and clears the event flag.
- R6: A write to the upper half that follows a lower-half write arms the block with the combined value. A compare value already passed then fires on the next cycle.
- R7: A write to the upper half without a preceding lower-half write updates the stored half but does not arm the block.
- R8: The event flag is sticky. Writing 1 to control bit 0 clears it, and a new match sets it again.
- R9: The comparison spans all 64 bits, so a carry into the upper half is honoured.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| time_now | input | 64 | Current time value |
| wr_en | input | 1 | Register write strobe |
| wr_sel | input | 2 | Register select for writes |
| wr_data | input | 32 | Write data |
| rd_sel | input | 2 | Register select for reads |
| rd_data | output | 32 | Registered read data, valid one cycle after rd_sel |
| alarm_evt | output | 1 | Sticky alarm event flag |
| start_pulse | output | 1 | One-cycle start strobe on a match |

## Verification
A wrong armed state shows at the ports within one clock. If the block stays armed when it should not, an extra start strobe appears. If it fails to arm, the expected strobe is missing. The armed bit in the control readback confirms which of the two happened. A fault in how the two halves combine, or in the 64-bit comparison, moves the strobe to the wrong time. The bench detects this because every expected strobe is tied to the cycle in which the triggering time or write was applied.

// File: rtl/tac_pkg.sv
package tac_pkg;
  typedef enum logic [1:0] {
    SEL_LO  = 2'd0,
    SEL_HI  = 2'd1,
    SEL_CTL = 2'd2
  } reg_sel_e;
  localparam int CTL_EVT_BIT = 0;
  localparam int CTL_ARM_BIT = 1;
endpackage

// File: rtl/tac_regs.sv
module tac_regs import tac_pkg::*; #(
  parameter int HALF_W = 32,
  parameter int SEL_W  = 2
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                wr_en,
  input  logic [SEL_W-1:0]    wr_sel,
  input  logic [HALF_W-1:0]   wr_data,
  input  logic                fire,
  output logic [2*HALF_W-1:0] alarm_val,
  output logic                armed,
  output logic                evt,
  output logic                lo_wr
);
  logic [HALF_W-1:0] lo_q, hi_q;
  logic              pend_q;
  logic              hi_wr, clr_wr;

  assign lo_wr  = wr_en && (wr_sel == SEL_LO);
  assign hi_wr  = wr_en && (wr_sel == SEL_HI);
  assign clr_wr = wr_en && (wr_sel == SEL_CTL) && wr_data[CTL_EVT_BIT];
  assign alarm_val = {hi_q, lo_q};

  always_ff @(posedge clk) begin
    if (rst) begin
      lo_q   <= '1;
      hi_q   <= '1;
      pend_q <= 1'b0;
      armed  <= 1'b1;
      evt    <= 1'b0;
    end else begin
      if (lo_wr) lo_q <= wr_data;
      if (hi_wr) hi_q <= wr_data;
      if (lo_wr)      pend_q <= 1'b1;
      else if (hi_wr) pend_q <= 1'b0;
      if (lo_wr)                armed <= 1'b0;
      else if (hi_wr && pend_q) armed <= 1'b1;
      else if (fire)            armed <= 1'b0;
      if (fire)                 evt <= 1'b1;
      else if (lo_wr || clr_wr) evt <= 1'b0;
    end
  end

  // R5: lower-half write disarms
  a_r5_lo_disarms: assert property (@(posedge clk) disable iff (rst)
    lo_wr |=> !armed);
  // R6: lower then upper arms
  a_r6_pair_arms: assert property (@(posedge clk) disable iff (rst)
    (hi_wr && pend_q) |=> armed);
  // R7: lone upper write leaves a disarmed block disarmed
  a_r7_hi_alone: assert property (@(posedge clk) disable iff (rst)
    (hi_wr && !pend_q && !armed) |=> !armed);
  // R8: flag holds unless cleared
  a_r8_evt_sticky: assert property (@(posedge clk) disable iff (rst)
    (evt && !lo_wr && !clr_wr) |=> evt);
endmodule

// File: rtl/tac_cmp.sv
module tac_cmp #(
  parameter int TIME_W = 64
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [TIME_W-1:0] time_now,
  input  logic [TIME_W-1:0] alarm_val,
  input  logic              armed,
  input  logic              block,
  output logic              fire,
  output logic              start_q
);
  assign fire = armed && !block && (time_now >= alarm_val);

  always_ff @(posedge clk) begin
    if (rst) start_q <= 1'b0;
    else     start_q <= fire;
  end

  // R3/R4: strobe is a single cycle, once per arming
  a_r4_single_strobe: assert property (@(posedge clk) disable iff (rst)
    start_q |=> !start_q);
  // R4: firing leaves the block disarmed
  a_r4_fire_disarms: assert property (@(posedge clk) disable iff (rst)
    fire |=> !fire);
endmodule

// File: rtl/time_alarm_cmp.sv
module time_alarm_cmp import tac_pkg::*; #(
  parameter int TIME_W = 64,
  parameter int SEL_W  = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [TIME_W-1:0] time_now,
  input  logic              wr_en,
  input  logic [SEL_W-1:0]  wr_sel,
  input  logic [TIME_W/2-1:0] wr_data,
  input  logic [SEL_W-1:0]  rd_sel,
  output logic [TIME_W/2-1:0] rd_data,
  output logic              alarm_evt,
  output logic              start_pulse
);
  localparam int HALF_W = TIME_W / 2;

  logic [TIME_W-1:0] alarm_val;
  logic              armed, evt, lo_wr, fire, start_q;
  logic [HALF_W-1:0] ctl_word;

  tac_regs #(.HALF_W(HALF_W), .SEL_W(SEL_W)) u_regs (
    .clk(clk), .rst(rst), .wr_en(wr_en), .wr_sel(wr_sel), .wr_data(wr_data),
    .fire(fire), .alarm_val(alarm_val), .armed(armed), .evt(evt), .lo_wr(lo_wr)
  );

  tac_cmp #(.TIME_W(TIME_W)) u_cmp (
    .clk(clk), .rst(rst), .time_now(time_now), .alarm_val(alarm_val),
    .armed(armed), .block(lo_wr), .fire(fire), .start_q(start_q)
  );

  always_comb begin
    ctl_word = '0;
    ctl_word[CTL_EVT_BIT] = evt;
    ctl_word[CTL_ARM_BIT] = armed;
  end

  always_ff @(posedge clk) begin
    if (rst) rd_data <= '0;
    else begin
      case (rd_sel)
        SEL_LO:  rd_data <= alarm_val[HALF_W-1:0];
        SEL_HI:  rd_data <= alarm_val[TIME_W-1:HALF_W];
        SEL_CTL: rd_data <= ctl_word;
        default: rd_data <= '0;
      endcase
    end
  end

  assign alarm_evt   = evt;
  assign start_pulse = start_q;

  // R3: a strobe is always accompanied by the event flag
  a_r3_strobe_has_evt: assert property (@(posedge clk) disable iff (rst)
    start_pulse |-> alarm_evt);
endmodule

// File: tb/sim_time_alarm_cmp.sv
module sim_time_alarm_cmp;
  localparam int CLK_PERIOD = 10;
  localparam int WD_LIMIT   = 5000;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [63:0] time_now = '0;
  logic        wr_en = 1'b0;
  logic [1:0]  wr_sel = '0;
  logic [31:0] wr_data = '0;
  logic [1:0]  rd_sel = '0;
  logic [31:0] rd_data;
  logic        alarm_evt, start_pulse;

  int checks = 0;
  int fails  = 0;
  int cyc    = 0;
  int exp_q[$];
  bit done   = 1'b0;

  time_alarm_cmp u0 (
    .clk(clk), .rst(rst), .time_now(time_now), .wr_en(wr_en), .wr_sel(wr_sel),
    .wr_data(wr_data), .rd_sel(rd_sel), .rd_data(rd_data),
    .alarm_evt(alarm_evt), .start_pulse(start_pulse)
  );

  always #(CLK_PERIOD/2) clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // monitor: every strobe must match the oldest expected cycle
  always @(negedge clk) begin
    if (!rst && !done && start_pulse) begin
      checks++;
      if (exp_q.size() == 0) begin
        fails++;
        $display("FAIL R2/R4 unexpected strobe actual=cycle %0d expected=none", cyc);
      end else begin
        int e;
        e = exp_q.pop_front();
        if (e != cyc) begin
          fails++;
          $display("FAIL R2 strobe cycle actual=%0d expected=%0d", cyc, e);
        end
      end
    end
  end

  task automatic expect_strobe();
    exp_q.push_back(cyc + 1);
  endtask

  task automatic wr(input logic [1:0] sel, input logic [31:0] d);
    @(negedge clk);
    wr_en = 1'b1; wr_sel = sel; wr_data = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic rd(input logic [1:0] sel, output logic [31:0] d);
    @(negedge clk);
    rd_sel = sel;
    @(negedge clk);
    d = rd_data;
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic set_time(input logic [63:0] t);
    @(negedge clk);
    time_now = t;
  endtask

  task automatic finish_run();
    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  endtask

  initial begin
    repeat (WD_LIMIT) @(posedge clk);
    fails++; checks++;
    $display("FAIL watchdog actual=timeout expected=completion");
    finish_run();
  end

  initial begin
    logic [31:0] d;
    repeat (3) @(negedge clk);
    rst = 1'b0;

    // R1 reset state
    chk("R1 start_pulse", start_pulse, 0);
    chk("R1 alarm_evt", alarm_evt, 0);
    rd(2'd0, d); chk("R1 lo reset", d, 32'hFFFF_FFFF);
    rd(2'd1, d); chk("R1 hi reset", d, 32'hFFFF_FFFF);
    rd(2'd2, d); chk("R1 ctl armed", d, 32'h2);

    // R2 reset value fires only at the all-ones time
    set_time(64'hFFFF_FFFF_FFFF_FFFF); expect_strobe();
    idle(2);
    chk("R3 evt after fire", alarm_evt, 1);
    set_time(64'd0);
    rd(2'd2, d); chk("R4 disarmed after fire", d, 32'h1);

    // R8 clear by writing one
    wr(2'd2, 32'h1);
    chk("R8 evt cleared", alarm_evt, 0);

    // R6/R2 arm at 1000, equal time fires
    set_time(64'd500);
    wr(2'd0, 32'd1000);
    wr(2'd1, 32'd0);
    idle(3);
    rd(2'd2, d); chk("R6 armed", d, 32'h2);
    set_time(64'd1000); expect_strobe();
    idle(2);
    chk("R2 evt on equal", alarm_evt, 1);
    // R4 no second strobe
    for (int t = 1001; t < 1006; t++) set_time(64'(t));
    idle(2);
    chk("R4 queue drained", 64'(exp_q.size()), 0);
    chk("R8 evt still set", alarm_evt, 1);

    // R5 lower write clears flag and disarms
    wr(2'd0, 32'd200);
    chk("R5 evt cleared by lo", alarm_evt, 0);
    rd(2'd2, d); chk("R5 ctl disarmed", d, 32'h0);
    idle(3);
    // R6 past value fires at once
    wr(2'd1, 32'd0); expect_strobe();
    idle(2);
    chk("R6 past fires", alarm_evt, 1);

    // R7 lone upper write does not arm
    wr(2'd1, 32'd0);
    idle(3);
    rd(2'd2, d); chk("R7 not armed", d, 32'h1);

    // R5 lower write cancels a pending arming
    wr(2'd0, 32'd5000);
    wr(2'd1, 32'd0);
    set_time(64'd100);
    wr(2'd0, 32'd6000);
    set_time(64'd7000);
    idle(3);
    rd(2'd2, d); chk("R5 cancel disarmed", d, 32'h0);
    rd(2'd0, d); chk("R5 lo stored", d, 32'd6000);
    wr(2'd1, 32'd0); expect_strobe();
    idle(2);

    // R2 greater-than jump
    wr(2'd0, 32'd9000);
    wr(2'd1, 32'd0);
    idle(2);
    set_time(64'd20000); expect_strobe();
    idle(2);
    chk("R2 evt on greater", alarm_evt, 1);

    // R9 compare spans the half boundary
    set_time(64'h0000_0000_FFFF_FFFF);
    wr(2'd0, 32'd0);
    wr(2'd1, 32'd1);
    idle(3);
    chk("R9 no fire below", alarm_evt, 0);
    set_time(64'h0000_0001_0000_0000); expect_strobe();
    idle(2);
    chk("R9 fire at carry", alarm_evt, 1);

    idle(3);
    chk("R2 all strobes seen", 64'(exp_q.size()), 0);
    finish_run();
  end
endmodule